// File: doc/BRIEF.md
# Configuration Image Command Queue

This block sits between software and the data mover that streams a configuration image into a device's configuration port. Software describes each transfer by writing four registers: source address, destination address, source length (in 32-bit words) and destination length. The write to the destination length register commits the staged command into a four-entry queue. A status register reports whether the queue is full or empty, so software can keep feeding commands until the full flag rises.

The block hands queued commands, one at a time, to the data mover over a valid/ready handshake and waits for its completion pulse. A command whose source address has bit 0 set is the final one of an image. Its completion is reported twice: the ordinary transfer-done event when the mover finishes, and a separate combined event only after the configuration port reports that it has drained. No further command is dispatched until that drain is seen. Events gather in a write-one-to-clear interrupt status register; a mask register selects which of them drive the interrupt line. Register writes are blocked until a key is written to the unlock register.

Top module: `cfgdma_cmdq`

## Requirements
- R1: After reset the device is locked (lock register reads 1), the mask register reads 0xFFFFFFFF, the interrupt status register reads 0, the status register reads 0x40000000 (bit 30, queue empty) and the interrupt output is low.
- R2: While locked, a write to any offset other than unlock (0x34) leaves every register unchanged; writing 0x757BDF0D to 0x34 unlocks (lock register 0x04 reads 0); writing a value with bit 0 set to 0x04 while unlocked locks again.
- R3: A write to the destination length register (0x24) pushes the staged source address (0x18), destination address (0x1C) and source length (0x20) as one command; status bit 31 reads 1 when four commands are held and bit 30 reads 1 when none are; commands leave in the order they were pushed, with the source length passed on unchanged as a word count and the source address with bit 0 cleared.
- R4: A push while the queue is full is dropped and sets interrupt status bit 5 (overflow).
- R5: A push whose staged source address has bits 2:1 non-zero is discarded and sets interrupt status bit 6 (misaligned source); the queue contents are unchanged.
- R6: A command is offered to the mover only while control register (0x00) bit 26 is 1 and miscellaneous control (0x80) bit 4 is 0; control bits 26 and 27 read back as written; at most one command is outstanding at a time.
- R7: A completion pulse from the mover sets interrupt status bit 13.
- R8: For a command with source bit 0 set, the mover output flags it as last; its completion sets bit 13, and bit 12 is set only once the port-drained input is high; no other command is offered in between.
- R9: A pulse on the configuration-done input sets interrupt status bit 2.
- R10: Writing 1s to the interrupt status register (0x0C) clears those bits, but an event arriving in the same cycle keeps its bit set.
- R11: The interrupt output is high exactly when some interrupt status bit is 1 and its mask register (0x10) bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| cmd_valid | output | 1 | A command is offered to the data mover |
| cmd_ready | input | 1 | Data mover accepts the offered command |
| cmd_src | output | 32 | Source address, bit 0 cleared |
| cmd_dst | output | 32 | Destination address |
| cmd_len | output | 32 | Source length in 32-bit words |
| cmd_last | output | 1 | Command is the final one of an image |
| xfer_done | input | 1 | Data mover finished the outstanding command |
| port_idle | input | 1 | Configuration port has drained all data |
| cfg_done | input | 1 | Configuration port reports configuration complete |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the drain window after a final command: the mover has finished, the port has not yet drained, and another command is already waiting in the queue, so the block must hold that command back and withhold bit 12. The stimulus queues a final command followed by an ordinary one, holds the port-drained input low after completing the final transfer, and watches the dispatch output and status for several cycles before releasing it. A same-cycle clear and set of the interrupt status register is reached by writing the clear in the cycle the configuration-done pulse arrives.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LOCK  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ISTS  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_SRC   = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_DST   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SLEN  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DLEN  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_UNLK  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_MISC  = 8'h80;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h757B_DF0D;
    localparam logic [DATA_W-1:0] IMPL_BITS  = 32'hF8F7_F87F;

    localparam int B_PATH_EN  = 26;
    localparam int B_PARTIAL  = 27;
    localparam int B_LOOPBACK = 4;
    localparam int B_Q_FULL   = 31;
    localparam int B_Q_EMPTY  = 30;
    localparam int B_EV_XFER  = 13;
    localparam int B_EV_DRAIN = 12;
    localparam int B_EV_OVF   = 5;
    localparam int B_EV_ALIGN = 6;
    localparam int B_EV_CFG   = 2;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_BUSY  = 2'd1,
        SQ_DRAIN = 2'd2
    } seq_st_t;
endpackage

// File: rtl/cfgdma_fifo.sv
module cfgdma_fifo
    import cfgdma_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  cmd_t             wdata,
    input  logic             pop,
    output cmd_t             rdata,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    cmd_t mem_q [DEPTH];

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

    logic do_push, do_pop;

    always_comb begin
        do_push = push && (ptr_q.cnt != CNT_MAX);
        do_pop  = pop && (ptr_q.cnt != '0);
        ptr_d   = ptr_q;
        if (do_push) begin
            ptr_d.wp = (ptr_q.wp == PTR_MAX) ? '0 : ptr_q.wp + 1'b1;
        end
        if (do_pop) begin
            ptr_d.rp = (ptr_q.rp == PTR_MAX) ? '0 : ptr_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   ptr_d.cnt = ptr_q.cnt + 1'b1;
            2'b01:   ptr_d.cnt = ptr_q.cnt - 1'b1;
            default: ptr_d.cnt = ptr_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (ptr_q.wp == PTR_W'(gi))) begin
                mem_q[gi] <= wdata;
            end
        end
    end

    assign rdata = mem_q[ptr_q.rp];
    assign full  = (ptr_q.cnt == CNT_MAX);
    assign empty = (ptr_q.cnt == '0);
    assign count = ptr_q.cnt;
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
    import cfgdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic q_empty,
    input  logic dispatch_en,
    input  logic head_last,
    input  logic cmd_ready,
    input  logic xfer_done,
    input  logic port_idle,
    output logic cmd_valid,
    output logic pop,
    output logic ev_xfer,
    output logic ev_drain,
    output logic in_drain
);
    typedef struct packed {
        seq_st_t st;
        logic    last;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        cmd_valid = 1'b0;
        pop       = 1'b0;
        ev_xfer   = 1'b0;
        ev_drain  = 1'b0;
        case (s_q.st)
            SQ_IDLE: begin
                cmd_valid = dispatch_en && !q_empty;
                if (cmd_valid && cmd_ready) begin
                    pop       = 1'b1;
                    s_d.st    = SQ_BUSY;
                    s_d.last  = head_last;
                end
            end
            SQ_BUSY: begin
                if (xfer_done) begin
                    ev_xfer = 1'b1;
                    s_d.st  = s_q.last ? SQ_DRAIN : SQ_IDLE;
                end
            end
            SQ_DRAIN: begin
                if (port_idle) begin
                    ev_drain = 1'b1;
                    s_d.st   = SQ_IDLE;
                    s_d.last = 1'b0;
                end
            end
            default: s_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: SQ_IDLE, last: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_drain = (s_q.st == SQ_DRAIN);
endmodule

// File: rtl/cfgdma_cmdq.sv
module cfgdma_cmdq
    import cfgdma_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        cmd_valid,
    input  logic        cmd_ready,
    output logic [31:0] cmd_src,
    output logic [31:0] cmd_dst,
    output logic [31:0] cmd_len,
    output logic        cmd_last,
    input  logic        xfer_done,
    input  logic        port_idle,
    input  logic        cfg_done,
    output logic        irq
);
    typedef struct packed {
        logic              locked;
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] misc;
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] ists;
        cmd_t              stage;
    } regs_t;

    regs_t r_d, r_q;

    logic             wr_ok, push_req, push, misalign;
    logic             q_full, q_empty, pop, dispatch_en;
    logic             ev_xfer, ev_drain, in_drain;
    logic [CNT_W-1:0] q_count;
    logic [DATA_W-1:0] ev_set, w1c;
    cmd_t             head;

    assign wr_ok       = reg_we && (!r_q.locked || reg_addr == OFS_UNLK);
    assign push_req    = wr_ok && (reg_addr == OFS_DLEN);
    assign misalign    = (r_q.stage.src[2:1] != 2'b00);
    assign push        = push_req && !q_full && !misalign;
    assign dispatch_en = r_q.ctrl[B_PATH_EN] && !r_q.misc[B_LOOPBACK];

    cfgdma_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata ('{src: r_q.stage.src, dst: r_q.stage.dst, len: r_q.stage.len}),
        .pop   (pop),
        .rdata (head),
        .full  (q_full),
        .empty (q_empty),
        .count (q_count)
    );

    cfgdma_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_empty     (q_empty),
        .dispatch_en (dispatch_en),
        .head_last   (head.src[0]),
        .cmd_ready   (cmd_ready),
        .xfer_done   (xfer_done),
        .port_idle   (port_idle),
        .cmd_valid   (cmd_valid),
        .pop         (pop),
        .ev_xfer     (ev_xfer),
        .ev_drain    (ev_drain),
        .in_drain    (in_drain)
    );

    always_comb begin
        ev_set              = '0;
        ev_set[B_EV_XFER]   = ev_xfer;
        ev_set[B_EV_DRAIN]  = ev_drain;
        ev_set[B_EV_CFG]    = cfg_done;
        ev_set[B_EV_OVF]    = push_req && q_full;
        ev_set[B_EV_ALIGN]  = push_req && !q_full && misalign;
        w1c = (wr_ok && reg_addr == OFS_ISTS) ? reg_wdata : '0;
    end

    always_comb begin
        r_d      = r_q;
        r_d.ists = ((r_q.ists & ~w1c) | ev_set) & IMPL_BITS;
        if (reg_we && reg_addr == OFS_UNLK && reg_wdata == UNLOCK_KEY) begin
            r_d.locked = 1'b0;
        end
        if (wr_ok) begin
            case (reg_addr)
                OFS_CTRL:  r_d.ctrl      = reg_wdata;
                OFS_LOCK:  r_d.locked    = reg_wdata[0];
                OFS_IMASK: r_d.imask     = reg_wdata;
                OFS_MISC:  r_d.misc      = reg_wdata;
                OFS_SRC:   r_d.stage.src = reg_wdata;
                OFS_DST:   r_d.stage.dst = reg_wdata;
                OFS_SLEN:  r_d.stage.len = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.locked <= 1'b1;
            r_q.ctrl   <= '0;
            r_q.misc   <= '0;
            r_q.imask  <= '1;
            r_q.ists   <= '0;
            r_q.stage  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = r_q.ctrl;
            OFS_LOCK:  reg_rdata = {31'b0, r_q.locked};
            OFS_ISTS:  reg_rdata = r_q.ists;
            OFS_IMASK: reg_rdata = r_q.imask;
            OFS_STAT: begin
                reg_rdata[B_Q_FULL]  = q_full;
                reg_rdata[B_Q_EMPTY] = q_empty;
            end
            OFS_SRC:   reg_rdata = r_q.stage.src;
            OFS_DST:   reg_rdata = r_q.stage.dst;
            OFS_SLEN:  reg_rdata = r_q.stage.len;
            OFS_MISC:  reg_rdata = r_q.misc;
            default:   reg_rdata = '0;
        endcase
    end

    assign cmd_src  = {head.src[31:1], 1'b0};
    assign cmd_dst  = head.dst;
    assign cmd_len  = head.len;
    assign cmd_last = head.src[0];
    assign irq      = |(r_q.ists & ~r_q.imask);
endmodule

// File: rtl/cfgdma_cmdq_chk.sv
module cfgdma_cmdq_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [7:0]       reg_addr,
    input logic [31:0]      imask,
    input logic [31:0]      ctrl,
    input logic [31:0]      ists,
    input logic             locked,
    input logic [CNT_W-1:0] count,
    input logic             q_empty,
    input logic             q_full,
    input logic             push_req,
    input logic             pop,
    input logic             cmd_valid,
    input logic             in_drain
);
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    a_r6_offer_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !q_empty);

    a_r8_hold_while_drain: assert property (@(posedge clk) disable iff (!rst_n)
        in_drain |-> !cmd_valid);

    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && q_full && !pop) |=> (count == CNT_W'(DEPTH)));

    a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && reg_we && reg_addr != 8'h34) |=> ($stable(imask) && $stable(ctrl)));

    a_r8_drain_event_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ists[12]) |-> $past(in_drain));
endmodule

bind cfgdma_cmdq cfgdma_cmdq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .imask     (r_q.imask),
    .ctrl      (r_q.ctrl),
    .ists      (r_q.ists),
    .locked    (r_q.locked),
    .count     (q_count),
    .q_empty   (q_empty),
    .q_full    (q_full),
    .push_req  (push_req),
    .pop       (pop),
    .cmd_valid (cmd_valid),
    .in_drain  (in_drain)
);

// File: tb/cfgdma_cmdq_test.sv
module cfgdma_cmdq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid, cmd_last;
    logic        cmd_ready = 1'b0;
    logic [31:0] cmd_src, cmd_dst, cmd_len;
    logic        xfer_done = 1'b0;
    logic        port_idle = 1'b1;
    logic        cfg_done = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    logic [31:0] q_src [$];
    logic [31:0] q_dst [$];
    logic [31:0] q_len [$];

    always #2.5 clk = ~clk;

    cfgdma_cmdq uut (.*);

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_status(input int held);
        logic [31:0] v = '0;
        v[31] = (held == 4);
        v[30] = (held == 0);
        return v;
    endfunction

    function automatic logic [31:0] rand_src();
        return {$urandom() & 32'hFFFF_FFF8};
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic push(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
        wr(8'h18, s); wr(8'h1C, d); wr(8'h20, l); wr(8'h24, 32'h0);
    endtask

    task automatic push_model(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
        push(s, d, l);
        q_src.push_back(s); q_dst.push_back(d); q_len.push_back(l);
    endtask

    task automatic serve(input string tag);
        logic [31:0] es, ed, el;
        int w = 0;
        es = q_src.pop_front(); ed = q_dst.pop_front(); el = q_len.pop_front();
        while (!cmd_valid && w < 40) begin
            @(negedge clk); w++;
        end
        check({tag, " R6 offered"}, {31'b0, cmd_valid}, 32'h1);
        check({tag, " R3 src order"}, cmd_src, {es[31:1], 1'b0});
        check({tag, " R3 dst"}, cmd_dst, ed);
        check({tag, " R3 len words"}, cmd_len, el);
        check({tag, " R8 last flag"}, {31'b0, cmd_last}, {31'b0, es[0]});
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        check({tag, " R6 one outstanding"}, {31'b0, cmd_valid}, 32'h0);
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(negedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got 0x0 expected 0x1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        void'($urandom(32'h0C0F_FEE5));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h14, v); check("R1 status", v, exp_status(0));
        rd(8'h04, v); check("R1 lock", v, 32'h1);
        rd(8'h10, v); check("R1 mask", v, 32'hFFFF_FFFF);
        rd(8'h0C, v); check("R1 ists", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 lock gating
        wr(8'h10, 32'h0);
        rd(8'h10, v); check("R2 locked mask write ignored", v, 32'hFFFF_FFFF);
        wr(8'h34, 32'h1234_5678);
        rd(8'h04, v); check("R2 wrong key", v, 32'h1);
        wr(8'h34, 32'h757B_DF0D);
        rd(8'h04, v); check("R2 unlocked", v, 32'h0);

        // R3 fill queue with dispatch off
        for (int i = 0; i < 4; i++) begin
            push_model(rand_src(), $urandom(), 32'($urandom_range(1, 4096)));
            rd(8'h14, v); check("R3 status fill", v, exp_status(i + 1));
        end
        check("R6 no offer when disabled", {31'b0, cmd_valid}, 32'h0);

        // R4 overflow
        push(32'h0000_1000, 32'hFFFF_FFFF, 32'd7);
        rd(8'h0C, v); check("R4 overflow bit", v, 32'h0000_0020);
        rd(8'h14, v); check("R4 still full", v, exp_status(4));
        check("R11 masked irq low", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h0000_0020);
        rd(8'h0C, v); check("R10 clear", v, 32'h0);

        // R6 loopback blocks dispatch
        wr(8'h80, 32'h0000_0010);
        wr(8'h00, 32'h0C00_0000);
        rd(8'h00, v); check("R6 ctrl readback", v, 32'h0C00_0000);
        repeat (3) @(negedge clk);
        check("R6 loopback blocks", {31'b0, cmd_valid}, 32'h0);
        wr(8'h80, 32'h0);

        // R3/R7 drain in order
        for (int i = 0; i < 4; i++) begin
            serve("R3 fifo");
            rd(8'h0C, v); check("R7 xfer done bit", v, 32'h0000_2000);
            wr(8'h0C, 32'h0000_2000);
        end
        rd(8'h14, v); check("R3 empty after drain", v, exp_status(0));

        // R5 misaligned source
        push(32'h0000_2004, 32'h0, 32'd3);
        rd(8'h0C, v); check("R5 align bit", v, 32'h0000_0040);
        rd(8'h14, v); check("R5 discarded", v, exp_status(0));
        wr(8'h0C, 32'h0000_0040);

        // R11 irq via mask
        wr(8'h10, ~32'h0000_2000);
        push_model(32'h0001_0000, 32'hFFFF_FFFF, 32'd16);
        serve("R11");
        check("R11 irq on unmasked", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_2000);
        check("R11 irq after clear", {31'b0, irq}, 32'h0);

        // R8 last command with drain wait
        wr(8'h10, ~32'h0000_1000);
        port_idle = 1'b0;
        push_model(32'h0002_0001, 32'hFFFF_FFFF, 32'd64);
        push_model(32'h0003_0000, 32'hFFFF_FFFF, 32'd8);
        serve("R8 last");
        rd(8'h0C, v); check("R8 xfer only before drain", v, 32'h0000_2000);
        check("R8 irq waits drain", {31'b0, irq}, 32'h0);
        repeat (5) @(negedge clk);
        check("R8 no offer during drain", {31'b0, cmd_valid}, 32'h0);
        rd(8'h0C, v); check("R8 bit12 still clear", v, 32'h0000_2000);
        port_idle = 1'b1;
        @(negedge clk);
        rd(8'h0C, v); check("R8 drain bit", v, 32'h0000_3000);
        check("R8 irq after drain", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h0000_3000);
        serve("R8 follower");
        wr(8'h0C, 32'h0000_2000);

        // R9 / R10 configuration done
        cfg_done = 1'b1; @(negedge clk); cfg_done = 1'b0;
        rd(8'h0C, v); check("R9 cfg done bit", v, 32'h0000_0004);
        reg_addr = 8'h0C; reg_wdata = 32'h4; reg_we = 1'b1; cfg_done = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; cfg_done = 1'b0;
        rd(8'h0C, v); check("R10 set wins over clear", v, 32'h0000_0004);
        wr(8'h0C, 32'h4);
        rd(8'h0C, v); check("R10 cleared", v, 32'h0);

        // random rounds
        for (int r = 0; r < 12; r++) begin
            int k = $urandom_range(1, 4);
            for (int j = 0; j < k; j++) begin
                push_model(rand_src(), $urandom(), 32'($urandom_range(1, 65535)));
            end
            rd(8'h14, v); check("R3 random fill", v, exp_status(k));
            for (int j = 0; j < k; j++) serve("R3 random");
            rd(8'h0C, v); check("R7 random done", v, 32'h0000_2000);
            wr(8'h0C, 32'hFFFF_FFFF);
        end

        // R2 relock
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R2 relocked", v, 32'h1);
        wr(8'h00, 32'h0);
        rd(8'h00, v); check("R2 ctrl kept", v, 32'h0C00_0000);

        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule